// File: doc/BRIEF.md
# Down-Counting Timer Channel With Two Match Points

This block is a single timer channel that counts down from a programmable start value. The count advances once for each pulse on a tick input, so the caller decides the time base. Each countdown period can produce up to three ordered events. The first fires when the count reaches the larger of two compare values. The second fires when it reaches the smaller one. The third fires when the count arrives at zero. Software may write the two compare values in either order, because the channel works out which one is larger.

The channel is started through a control register. Setting the run bit loads the start value into the count. When the count has reached zero, the next tick restarts it from the start value if that value is nonzero. A start value of zero leaves the channel parked at zero. Each kind of event has its own enable bit. The single interrupt line changes level once for every cycle in which at least one enabled event occurs. A write-and-read register port gives access to the control, start and compare values, and the live count can be read through it.

Top module: `dctimer_dual_match`

## Requirements
- R1: After reset the count, the start value, both compare values, the control register and the interrupt line all read as zero.
- R2: A control write that changes the run bit (bit 0) from 0 to 1 copies the start value into the count in that same cycle, and a tick in that cycle is ignored. A control write while the channel is already running leaves the count unchanged.
- R3: While the channel is running, each tick lowers a nonzero count by exactly one. While it is stopped, ticks leave the count unchanged.
- R4: When the count steps down to the larger compare value, the interrupt level toggles if the high-compare enable (control bit 1) is set.
- R5: When the count steps down to the smaller compare value, the interrupt level toggles if the low-compare enable (control bit 2) is set. If the two compare values are equal, only one event occurs, and it is governed by bit 1.
- R6: When the count steps down from one to zero, the interrupt level toggles if the zero enable (control bit 3) is set.
- R7: If several enabled events occur in the same cycle, the interrupt level toggles only once.
- R8: A tick at count zero reloads a nonzero start value and raises no event. With a start value of zero, the count stays at zero and no events occur.
- R9: Writing the start value while the channel runs leaves the current count unchanged. The new value is used at the next reload.
- R10: Register addresses are 0 control, 1 start value, 2 compare A, 3 compare B and 4 live count. The live count cannot be written. Unmapped addresses read as zero.
- R11: An event whose enable bit is clear does not change the interrupt level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| tick | input | 1 | Count advance pulse |
| irq | output | 1 | Interrupt level, toggled per event cycle |

## Verification
Two functions can land in the same cycle. The first case is a compare value of zero: that match event and the zero event then fall on the same tick. The bench sets compare A to zero with every enable on, counts down to zero, and expects exactly one change of the interrupt level. The second case is a control write that starts the channel while a tick is also high. The bench expects the count to equal the start value, not one less.

// File: rtl/dcm_pkg.sv
package dcm_pkg;

  localparam int unsigned REG_AW = 3;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_CMP_A  = 3'd2,
    A_CMP_B  = 3'd3,
    A_COUNT  = 3'd4
  } reg_addr_e;

  // bit0 run, bit1 high-compare enable, bit2 low-compare enable, bit3 zero enable
  typedef struct packed {
    logic ie_zero;
    logic ie_lo;
    logic ie_hi;
    logic run;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/dcm_regs.sv
module dcm_regs
  import dcm_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [W-1:0]      count_i,
  output logic [W-1:0]      rd_data,
  output ctrl_t             ctrl_o,
  output logic [W-1:0]      reload_o,
  output logic [W-1:0]      cmp_a_o,
  output logic [W-1:0]      cmp_b_o,
  output logic              load_o
);

  localparam int unsigned PAD_W = W - CTRL_W;

  logic wr_ctrl, wr_reload, wr_cmp_a, wr_cmp_b;

  always_comb begin
    wr_ctrl   = wr_en && (wr_addr == A_CTRL);
    wr_reload = wr_en && (wr_addr == A_RELOAD);
    wr_cmp_a  = wr_en && (wr_addr == A_CMP_A);
    wr_cmp_b  = wr_en && (wr_addr == A_CMP_B);
  end

  // start pulse: run goes from 0 to 1
  assign load_o = wr_ctrl && wr_data[0] && !ctrl_o.run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o   <= '0;
      reload_o <= '0;
      cmp_a_o  <= '0;
      cmp_b_o  <= '0;
    end else begin
      if (wr_ctrl)   ctrl_o   <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_reload) reload_o <= wr_data;
      if (wr_cmp_a)  cmp_a_o  <= wr_data;
      if (wr_cmp_b)  cmp_b_o  <= wr_data;
    end
  end

  always_comb begin
    case (reg_addr_e'(rd_addr))
      A_CTRL:   rd_data = {{PAD_W{1'b0}}, ctrl_o};
      A_RELOAD: rd_data = reload_o;
      A_CMP_A:  rd_data = cmp_a_o;
      A_CMP_B:  rd_data = cmp_b_o;
      A_COUNT:  rd_data = count_i;
      default:  rd_data = '0;
    endcase
  end

  // R10: a write to the count address touches no stored register
  p_count_ro_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_COUNT) |=> ($stable(reload_o) && $stable(cmp_a_o) &&
                                       $stable(cmp_b_o) && $stable(ctrl_o)));

endmodule

// File: rtl/dcm_core.sv
module dcm_core #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] reload,
  input  logic [W-1:0] cmp_a,
  input  logic [W-1:0] cmp_b,
  output logic [W-1:0] count,
  output logic         evt_hi,
  output logic         evt_lo,
  output logic         evt_zero
);

  function automatic logic [W-1:0] f_hi(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [W-1:0] f_lo(input logic [W-1:0] a, input logic [W-1:0] b);
    return (a > b) ? b : a;
  endfunction

  function automatic logic [W-1:0] f_dec(input logic [W-1:0] v);
    return v - {{(W-1){1'b0}}, 1'b1};
  endfunction

  logic [W-1:0] hi_val, lo_val, nxt;
  logic         step, dec, restart;

  always_comb begin
    hi_val   = f_hi(cmp_a, cmp_b);
    lo_val   = f_lo(cmp_a, cmp_b);
    nxt      = f_dec(count);
    step     = run && tick && !load;
    dec      = step && (count != '0);
    restart  = step && (count == '0) && (reload != '0);
    evt_hi   = dec && (nxt == hi_val);
    evt_lo   = dec && (nxt == lo_val) && (lo_val != hi_val);
    evt_zero = dec && (nxt == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       count <= '0;
    else if (load)    count <= reload;
    else if (dec)     count <= nxt;
    else if (restart) count <= reload;
  end

  // R2: a start always lands the start value
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(reload));

  // R3: a tick while running lowers a nonzero count by one
  p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !load && count != '0) |=> count == $past(count) - 1);

  // R3: stopped means frozen
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(count));

  // R6: the zero event only comes from a count of one
  p_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    evt_zero |-> count == {{(W-1){1'b0}}, 1'b1});

  // R8: with a zero start value the channel stays parked at zero
  p_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && reload == '0 && !load) |=> count == '0);

  // R5: the two compare events never coincide
  p_one_cmp_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_hi && evt_lo));

endmodule

// File: rtl/dcm_irq.sv
module dcm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_hi,
  input  logic evt_lo,
  input  logic evt_zero,
  input  logic ie_hi,
  input  logic ie_lo,
  input  logic ie_zero,
  output logic irq
);

  logic fire;

  assign fire = (evt_hi && ie_hi) || (evt_lo && ie_lo) || (evt_zero && ie_zero);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    irq <= 1'b0;
    else if (fire) irq <= ~irq;
  end

  // R7: one change per event cycle, however many events
  p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> irq != $past(irq));

  // R11: no enabled event, no change
  p_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(irq));

endmodule

// File: rtl/dctimer_dual_match.sv
module dctimer_dual_match
  import dcm_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [W-1:0]      wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [W-1:0]      rd_data,
  input  logic              tick,
  output logic              irq
);

  ctrl_t        ctrl;
  logic [W-1:0] reload, cmp_a, cmp_b, count;
  logic         load, evt_hi, evt_lo, evt_zero;

  dcm_regs #(.W(W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_addr  (rd_addr),
    .count_i  (count),
    .rd_data  (rd_data),
    .ctrl_o   (ctrl),
    .reload_o (reload),
    .cmp_a_o  (cmp_a),
    .cmp_b_o  (cmp_b),
    .load_o   (load)
  );

  dcm_core #(.W(W)) u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (ctrl.run),
    .tick     (tick),
    .load     (load),
    .reload   (reload),
    .cmp_a    (cmp_a),
    .cmp_b    (cmp_b),
    .count    (count),
    .evt_hi   (evt_hi),
    .evt_lo   (evt_lo),
    .evt_zero (evt_zero)
  );

  dcm_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt_hi   (evt_hi),
    .evt_lo   (evt_lo),
    .evt_zero (evt_zero),
    .ie_hi    (ctrl.ie_hi),
    .ie_lo    (ctrl.ie_lo),
    .ie_zero  (ctrl.ie_zero),
    .irq      (irq)
  );

  // R1: interrupt line low right after reset
  p_rst_irq_r1: assert property (@(posedge clk)
    $rose(rst_n) |-> !irq);

endmodule

// File: tb/sim_dctimer_dual_match.sv
module sim_dctimer_dual_match;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        tick = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // bench-side view of the channel
  logic [31:0] m_reload = 0, m_a = 0, m_b = 0, m_count = 0;
  logic [3:0]  m_ctrl = 0;
  logic        m_irq = 0;

  always #4 clk = ~clk;

  dctimer_dual_match u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tick(tick), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=0x%08h exp=0x%08h", tag, got, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    rd_addr = a;
    #1;
    v = rd_data;
  endtask

  task automatic check_count(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    rd(3'd4, v);
    check(tag, v, exp);
  endtask

  task automatic check_irq(input string tag);
    check(tag, {31'd0, irq}, {31'd0, m_irq});
  endtask

  // register write; tk also raises tick in the same cycle
  task automatic wr(input logic [2:0] a, input logic [31:0] d, input bit tk = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d; tick = tk;
    @(negedge clk);
    wr_en = 0; tick = 0;
    case (a)
      3'd0: begin
        if (d[0] && !m_ctrl[0]) m_count = m_reload;
        m_ctrl = d[3:0];
      end
      3'd1: m_reload = d;
      3'd2: m_a = d;
      3'd3: m_b = d;
      default: ;
    endcase
  endtask

  task automatic model_step();
    logic [31:0] hi, lo, nc;
    bit f;
    if (!m_ctrl[0]) return;
    if (m_count != 0) begin
      nc = m_count - 1;
      hi = (m_a > m_b) ? m_a : m_b;
      lo = (m_a > m_b) ? m_b : m_a;
      f = 0;
      if (nc == hi && m_ctrl[1]) f = 1;
      if (nc == lo && lo != hi && m_ctrl[2]) f = 1;
      if (nc == 0 && m_ctrl[3]) f = 1;
      if (f) m_irq = ~m_irq;
      m_count = nc;
    end else if (m_reload != 0) begin
      m_count = m_reload;
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick = 1;
      @(negedge clk);
      tick = 0;
      model_step();
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      check("R1 reg after reset", v, 0);
    end
    check("R1 irq after reset", {31'd0, irq}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    wr(3'd1, 10); wr(3'd2, 3); wr(3'd3, 7);
    rd(3'd2, v); check("R10 compare A readback", v, 3);
    rd(3'd3, v); check("R10 compare B readback", v, 7);
    wr(3'd0, 32'hF);
    check_count("R2 start loads count", 10);
    check("R1 irq still low", {31'd0, irq}, 0);
    ticks(3);
    check_count("R3 count after 3 ticks", 7);
    check("R4 high compare toggles", {31'd0, irq}, 1);
    ticks(4);
    check_count("R3 count after 7 ticks", 3);
    check("R5 low compare toggles", {31'd0, irq}, 0);
    ticks(3);
    check_count("R6 count at zero", 0);
    check("R6 zero toggles", {31'd0, irq}, 1);
    ticks(1);
    check_count("R8 restart from start value", 10);
    check("R8 restart raises no event", {31'd0, irq}, 1);
    check_irq("R4 model agrees");
  endtask

  task automatic t_mask();
    wr(3'd0, 0);
    wr(3'd1, 5); wr(3'd2, 4); wr(3'd3, 2);
    wr(3'd0, 32'h9);
    ticks(1);
    check_count("R11 count at high compare", 4);
    check_irq("R11 masked high compare");
    ticks(2);
    check_irq("R11 masked low compare");
    ticks(2);
    check_count("R6 masked run reaches zero", 0);
    check_irq("R6 enabled zero still toggles");
  endtask

  task automatic t_equal();
    logic i0;
    wr(3'd0, 0);
    wr(3'd1, 4); wr(3'd2, 2); wr(3'd3, 2);
    wr(3'd0, 32'h7);
    i0 = irq;
    ticks(2);
    check("R5 equal compares give one event", {31'd0, irq}, {31'd0, ~i0});
    check_irq("R5 model agrees");
  endtask

  task automatic t_collide();
    logic i0;
    wr(3'd0, 0);
    wr(3'd1, 6); wr(3'd2, 0); wr(3'd3, 5);
    wr(3'd0, 32'hF);
    ticks(1);
    check_irq("R4 compare B at 5");
    ticks(4);
    i0 = irq;
    ticks(1);
    check_count("R7 reaches zero", 0);
    check("R7 compare and zero together toggle once", {31'd0, irq}, {31'd0, ~i0});
  endtask

  task automatic t_park();
    logic i0;
    wr(3'd0, 0);
    wr(3'd1, 0);
    wr(3'd0, 32'hF);
    check_count("R8 zero start value", 0);
    i0 = irq;
    ticks(3);
    check_count("R8 parked at zero", 0);
    check("R8 no events while parked", {31'd0, irq}, {31'd0, i0});
  endtask

  task automatic t_reload_live();
    wr(3'd0, 0);
    wr(3'd1, 20); wr(3'd2, 30); wr(3'd3, 30);
    wr(3'd0, 32'h1);
    ticks(2);
    check_count("R3 running count", 18);
    wr(3'd1, 9);
    check_count("R9 start write keeps count", 18);
    ticks(18);
    check_count("R9 old run reaches zero", 0);
    ticks(1);
    check_count("R9 new start value used", 9);
  endtask

  task automatic t_start_tick();
    wr(3'd0, 0);
    wr(3'd1, 4);
    wr(3'd0, 32'h1, 1);
    check_count("R2 start wins over tick", 4);
    ticks(1);
    wr(3'd0, 32'h3);
    check_count("R2 control rewrite while running", 3);
  endtask

  task automatic t_stopped();
    logic [31:0] v;
    wr(3'd0, 0);
    ticks(3);
    check_count("R3 stopped ignores ticks", 3);
    wr(3'd4, 32'h55);
    check_count("R10 count not writable", 3);
    rd(3'd1, v); check("R10 start value unchanged", v, 4);
    rd(3'd6, v); check("R10 unmapped reads zero", v, 0);
    rd(3'd0, v); check("R10 control readback", v, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_mask();
    t_equal();
    t_collide();
    t_park();
    t_reload_live();
    t_start_tick();
    t_stopped();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule